// File: doc/BRIEF.md
# Configuration Store Commit Controller

This block keeps a small volatile configuration byte array and a behavioural non-volatile copy of it. A serial host writes and reads the volatile bytes through a plain byte port. It asks for a commit by raising one control bit from 0 to 1. The controller then copies the array into the store one byte per programmable write interval. While it does this, a busy flag is set, and it can be read both on a dedicated pin and inside the status byte.

A power-on reset makes the controller reload the volatile array from the store. A persistent lock bit blocks any later commit, but only once that bit has itself been committed.

The controller has three states:
- `ST_LOAD` copies the store into the volatile array. It leaves for `ST_IDLE` after the last byte.
- `ST_IDLE` accepts host writes. It goes to `ST_WRITE` when the commit bit shows a 0-to-1 transition and the stored lock is clear.
- `ST_WRITE` commits bytes 1 upward, one every `WR_LAT` cycles. It returns to `ST_IDLE` after the last byte.

Reset forces `ST_LOAD`.

Top module: `nv_commit_ctrl`

## Requirements
- R1: After `rst_n` is released, the volatile array is loaded from the store, one byte per cycle in ascending address order. Host writes during this load are dropped. From `N_BYTES` cycles after release, every byte reads as the stored value.
- R2: While `fact_rst_n` is low, the store takes its factory image. Byte 0 equals `REV_CODE`, and byte i (i ≥ 1) equals `{i[3:0], 4'h0}`. This leaves the lock bit and the commit bit clear.
- R3: In `ST_IDLE`, a host write to byte 1..N_BYTES-1 is readable from the next cycle. Byte 0 ignores writes. Bit 6 of byte 1 ignores writes and instead reads the busy flag.
- R4: A commit starts only when bit 0 of byte 6 goes from 0 to 1. `nv_busy` (and bit 6 of byte 1) rises one cycle after the write that set the bit. A bit held at 1 starts nothing more.
- R5: Busy stays high for exactly `(N_BYTES-1)*WR_LAT` cycles. Bytes 1 to N_BYTES-1 are committed in ascending order, one per `WR_LAT` cycles.
- R6: While busy, host writes are dropped, but reads still return data.
- R7: Store byte 0 always holds `REV_CODE`; a commit never writes it.
- R8: After a commit and a fresh `rst_n`, the volatile array reads back the committed image.
- R9: The lock is bit 5 of byte 1. Setting it only in the volatile array does not block a commit. Once it is stored, further 0-to-1 transitions of the commit bit are ignored. Volatile writes still work while locked.
- R10: A commit bit that reads 1 straight after a reload starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fact_rst_n | input | 1 | Active-low factory reset of the store |
| rst_n | input | 1 | Active-low power-on reset; triggers a reload |
| reg_we | input | 1 | Host byte write strobe |
| reg_waddr | input | AW | Host write address |
| reg_wdata | input | 8 | Host write data |
| reg_raddr | input | AW | Host read address |
| reg_rdata | output | 8 | Host read data (combinational) |
| nv_busy | output | 1 | Commit in progress |

## Verification
Most wrong internal states show up at `nv_busy`:
- An edge detector that wrongly remembers the commit bit starts a commit in the cycle after a reload or a repeated level, or misses a real transition. Either is visible at `nv_busy` one cycle later.
- A wrong interval or index count makes the busy window longer or shorter than the count in R5. This shows when busy falls.

A store that took a wrong byte, or took the lock too early or too late, shows at the read port only after the next reload, which is `N_BYTES` cycles after reset release.

// File: rtl/nv_commit_pkg.sv
package nv_commit_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2
    } ctl_state_t;

    // Factory image: revision code at byte 0, index in the upper nibble elsewhere
    function automatic logic [7:0] factory_byte(input int unsigned idx, input logic [7:0] rev);
        logic [3:0] lo;
        lo = idx[3:0];
        if (idx == 0) return rev;
        return {lo, 4'h0};
    endfunction

endpackage

// File: rtl/nv_store.sv
module nv_store
    import nv_commit_pkg::*;
#(
    parameter int          N_BYTES  = 16,
    parameter int          AW       = 4,
    parameter logic [7:0]  REV_CODE = 8'h21
) (
    input  logic                 clk,
    input  logic                 fact_rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [7:0]           wdata,
    output logic [N_BYTES*8-1:0] mem_flat
);

    logic [7:0] mem [N_BYTES];

    always_ff @(posedge clk or negedge fact_rst_n) begin
        if (!fact_rst_n) begin
            for (int i = 0; i < N_BYTES; i++) begin
                mem[i] <= factory_byte(unsigned'(i), REV_CODE);
            end
        end else if (we && (32'(waddr) < N_BYTES)) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_flat
        assign mem_flat[g*8 +: 8] = mem[g];
    end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
    parameter int N_BYTES   = 16,
    parameter int AW        = 4,
    parameter int STAT_ADDR = 1,
    parameter int STAT_BIT  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [7:0]           host_data,
    input  logic                 load_we,
    input  logic [AW-1:0]        load_addr,
    input  logic [7:0]           load_data,
    input  logic                 busy,
    input  logic [AW-1:0]        raddr,
    output logic [7:0]           rdata,
    output logic [N_BYTES*8-1:0] vol_flat
);

    localparam logic [7:0] STAT_MASK = ~(8'(1) << STAT_BIT);

    logic [7:0] vol [N_BYTES];
    logic       host_ok;
    logic [7:0] host_val;

    assign host_ok  = host_we && (host_addr != '0) && (32'(host_addr) < N_BYTES);
    assign host_val = (32'(host_addr) == STAT_ADDR) ? (host_data & STAT_MASK) : host_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_BYTES; i++) begin
                vol[i] <= '0;
            end
        end else if (load_we) begin
            vol[load_addr] <= load_data;
        end else if (host_ok) begin
            vol[host_addr] <= host_val;
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(raddr) < N_BYTES) begin
            rdata = vol[raddr];
            if (32'(raddr) == STAT_ADDR) begin
                rdata[STAT_BIT] = busy;
            end
        end
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_flat
        assign vol_flat[g*8 +: 8] = vol[g];
    end

endmodule

// File: rtl/commit_fsm.sv
module commit_fsm
    import nv_commit_pkg::*;
#(
    parameter int N_BYTES = 16,
    parameter int AW      = 4,
    parameter int WR_LAT  = 4,
    parameter int LAT_W   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_bit,
    input  logic          lock_stored,
    output ctl_state_t    state_o,
    output logic [AW-1:0] idx_o,
    output logic          load_we,
    output logic          nv_we,
    output logic          host_open,
    output logic          busy
);

    ctl_state_t       state_q, state_d;
    logic [AW-1:0]    idx_q;
    logic [LAT_W-1:0] tmr_q;
    logic             prev_q;
    logic             last_idx, tick, start;

    assign last_idx = (32'(idx_q) == N_BYTES - 1);
    assign tick     = (32'(tmr_q) == WR_LAT - 1);
    assign start    = ctrl_bit && !prev_q && !lock_stored;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = last_idx ? ST_IDLE : ST_LOAD;
            ST_IDLE:  state_d = start ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = (tick && last_idx) ? ST_IDLE : ST_WRITE;
            default:  state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            tmr_q  <= '0;
            prev_q <= 1'b1;
        end else begin
            prev_q <= (state_q == ST_IDLE) ? ctrl_bit : 1'b1;
            unique case (state_q)
                ST_LOAD: idx_q <= last_idx ? '0 : idx_q + 1'b1;
                ST_IDLE: begin
                    tmr_q <= '0;
                    if (start) idx_q <= AW'(1);
                end
                ST_WRITE: begin
                    if (tick) begin
                        tmr_q <= '0;
                        idx_q <= last_idx ? '0 : idx_q + 1'b1;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: idx_q <= '0;
            endcase
        end
    end

    always_comb begin
        load_we   = (state_q == ST_LOAD);
        nv_we     = (state_q == ST_WRITE) && tick;
        host_open = (state_q == ST_IDLE);
        busy      = (state_q == ST_WRITE);
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
    import nv_commit_pkg::*;
#(
    parameter int         N_BYTES   = 16,
    parameter int         WR_LAT    = 4,
    parameter logic [7:0] REV_CODE  = 8'h21,
    parameter int         CTRL_ADDR = 6,
    parameter int         CTRL_BIT  = 0,
    parameter int         STAT_ADDR = 1,
    parameter int         STAT_BIT  = 6,
    parameter int         LOCK_BIT  = 5,
    localparam int        AW        = $clog2(N_BYTES),
    localparam int        LAT_W     = $clog2(WR_LAT + 1)
) (
    input  logic          clk,
    input  logic          fact_rst_n,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_waddr,
    input  logic [7:0]    reg_wdata,
    input  logic [AW-1:0] reg_raddr,
    output logic [7:0]    reg_rdata,
    output logic          nv_busy
);

    ctl_state_t           state;
    logic [AW-1:0]        idx;
    logic                 load_we, nv_we, host_open;
    logic [N_BYTES*8-1:0] vol_flat;
    logic [N_BYTES*8-1:0] store_flat;
    logic                 ctrl_bit, lock_stored;
    logic [7:0]           load_data, nv_wdata, store_byte0;

    assign ctrl_bit    = vol_flat[CTRL_ADDR*8 + CTRL_BIT];
    assign lock_stored = store_flat[STAT_ADDR*8 + LOCK_BIT];
    assign load_data   = store_flat[32'(idx)*8 +: 8];
    assign nv_wdata    = vol_flat[32'(idx)*8 +: 8];
    assign store_byte0 = store_flat[7:0];

    commit_fsm #(
        .N_BYTES(N_BYTES), .AW(AW), .WR_LAT(WR_LAT), .LAT_W(LAT_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_bit(ctrl_bit), .lock_stored(lock_stored),
        .state_o(state), .idx_o(idx), .load_we(load_we), .nv_we(nv_we),
        .host_open(host_open), .busy(nv_busy)
    );

    cfg_regs #(
        .N_BYTES(N_BYTES), .AW(AW), .STAT_ADDR(STAT_ADDR), .STAT_BIT(STAT_BIT)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(reg_we && host_open), .host_addr(reg_waddr), .host_data(reg_wdata),
        .load_we(load_we), .load_addr(idx), .load_data(load_data),
        .busy(nv_busy), .raddr(reg_raddr), .rdata(reg_rdata), .vol_flat(vol_flat)
    );

    nv_store #(
        .N_BYTES(N_BYTES), .AW(AW), .REV_CODE(REV_CODE)
    ) i_store (
        .clk(clk), .fact_rst_n(fact_rst_n), .we(nv_we), .waddr(idx),
        .wdata(nv_wdata), .mem_flat(store_flat)
    );

endmodule

// File: rtl/nv_commit_chk.sv
module nv_commit_chk
    import nv_commit_pkg::*;
#(
    parameter int         N_BYTES  = 16,
    parameter int         WR_LAT   = 4,
    parameter logic [7:0] REV_CODE = 8'h21
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fact_rst_n,
    input logic                 nv_busy,
    input logic                 ctrl_bit,
    input logic                 lock_stored,
    input logic [N_BYTES*8-1:0] vol_flat,
    input logic [7:0]           store_byte0
);

    localparam int TOTAL = (N_BYTES - 1) * WR_LAT;

    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_run <= '0;
        else if (nv_busy) busy_run <= busy_run + 1'b1;
        else              busy_run <= '0;
    end

    assert_rev_kept_R7: assert property (@(posedge clk) disable iff (!fact_rst_n)
        store_byte0 == REV_CODE);

    assert_frozen_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        nv_busy |=> $stable(vol_flat));

    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        (!nv_busy && $past(nv_busy)) |-> (32'(busy_run) == TOTAL));

    assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        $rose(nv_busy) |-> $past(!lock_stored));

    assert_start_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n || !fact_rst_n)
        $rose(nv_busy) |-> ($past(ctrl_bit) && !$past(ctrl_bit, 2)));

endmodule

bind nv_commit_ctrl nv_commit_chk #(
    .N_BYTES(N_BYTES), .WR_LAT(WR_LAT), .REV_CODE(REV_CODE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .fact_rst_n(fact_rst_n), .nv_busy(nv_busy),
    .ctrl_bit(ctrl_bit), .lock_stored(lock_stored), .vol_flat(vol_flat),
    .store_byte0(store_byte0)
);

// File: tb/test_nv_commit_ctrl.sv
module test_nv_commit_ctrl;

    localparam int         CLK_PERIOD = 10;
    localparam int         NB         = 16;
    localparam int         LAT        = 4;
    localparam logic [7:0] REV        = 8'h21;

    logic       clk = 1'b0;
    logic       fact_rst_n, rst_n, reg_we;
    logic [3:0] reg_waddr, reg_raddr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       nv_busy;

    int compared   = 0;
    int mismatched = 0;

    logic [7:0] exp_vol   [NB];
    logic [7:0] exp_store [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_commit_ctrl #(.N_BYTES(NB), .WR_LAT(LAT), .REV_CODE(REV)) i_nv_commit_ctrl (
        .clk(clk), .fact_rst_n(fact_rst_n), .rst_n(rst_n), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .nv_busy(nv_busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic read_byte(input int a, output logic [7:0] v);
        @(negedge clk);
        reg_raddr = 4'(a);
        #1 v = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int i = 0; i < NB; i++) begin
            read_byte(i, v);
            chk(req, v, exp_vol[i]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (NB + 4) @(negedge clk);
        for (int i = 0; i < NB; i++) exp_vol[i] = exp_store[i];
    endtask

    task automatic idle_watch(input string req, input int n);
        int seen;
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (nv_busy) seen++;
        end
        chk(req, 8'(seen), 8'd0);
    endtask

    // Write the commit bit and measure the busy window; optional blocked write probe
    task automatic commit_and_measure(input int probe);
        int cnt;
        logic seen_hi;
        logic [7:0] v;
        exp_vol[6] = exp_vol[6] | 8'h01;
        host_write(6, exp_vol[6]);
        chk("R4 busy not before next edge", 8'(nv_busy), 8'd0);
        cnt = 0; seen_hi = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (probe != 0 && i == 3) begin
                reg_we = 1'b1; reg_waddr = 4'd3; reg_wdata = ~exp_vol[3];
            end
            if (i == 4) reg_we = 1'b0;
            if (i == 0) chk("R4 busy rises one cycle after write", 8'(nv_busy), 8'd1);
            if (i == 6) begin
                reg_raddr = 4'd1;
                #1 chk("R4 status bit reads busy", reg_rdata & 8'h40, 8'h40);
            end
            if (nv_busy) begin cnt++; seen_hi = 1'b1; end
            else if (seen_hi) break;
        end
        chk("R5 busy length", 8'(cnt), 8'((NB-1)*LAT));
        for (int i = 1; i < NB; i++) exp_store[i] = exp_vol[i];
        if (probe != 0) begin
            read_byte(3, v);
            chk("R6 write during busy dropped", v, exp_vol[3]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        compared++; mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        fact_rst_n = 1'b0; rst_n = 1'b0; reg_we = 1'b0;
        reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
        for (int i = 0; i < NB; i++) exp_store[i] = (i == 0) ? REV : {4'(i), 4'h0};
        repeat (3) @(negedge clk);
        chk("R4 reset busy low", 8'(nv_busy), 8'd0);
        fact_rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: write during load is dropped (byte 2 already loaded)
        repeat (4) @(negedge clk);
        host_write(2, 8'hC3);
        repeat (NB) @(negedge clk);
        for (int i = 0; i < NB; i++) exp_vol[i] = exp_store[i];
        check_all("R1 R2 reload of factory image");

        // R3 sweep over all bytes
        for (int i = 0; i < NB; i++) begin
            d = 8'(i * 29 + 7);
            if (i == 6) d = d & 8'hFE;
            if (i == 1) d = 8'h4C;
            host_write(i, d);
            if (i == 1)      exp_vol[i] = d & 8'hBF;
            else if (i != 0) exp_vol[i] = d;
        end
        check_all("R3 host writes");
        idle_watch("R4 no commit without edge", 8);

        commit_and_measure(1);
        check_all("R6 reads after commit");
        idle_watch("R4 held level starts nothing", 12);

        do_reset();
        check_all("R8 committed image reloads");
        read_byte(0, v);
        chk("R7 byte 0 keeps revision", v, REV);
        idle_watch("R10 no commit after reload", 12);

        // R9: volatile lock alone does not block
        exp_vol[1] = exp_vol[1] | 8'h20;
        host_write(1, exp_vol[1]);
        exp_vol[6] = exp_vol[6] & 8'hFE;
        host_write(6, exp_vol[6]);
        commit_and_measure(0);
        exp_vol[6] = exp_vol[6] & 8'hFE;
        host_write(6, exp_vol[6]);
        host_write(6, exp_vol[6] | 8'h01);
        exp_vol[6] = exp_vol[6] | 8'h01;
        idle_watch("R9 stored lock blocks commit", 12);
        host_write(5, 8'h99);
        read_byte(5, v);
        chk("R9 volatile writes still work", v, 8'h99);
        do_reset();
        check_all("R9 R8 locked store unchanged");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule